// File: doc/BRIEF.md
# USB Host Interrupt Status Controller

This block keeps the interrupt event status for a USB host controller that follows the open host controller model, and it drives the controller's two interrupt lines. The host controller core sends it one-cycle event strobes: schedule overrun, done-queue writeback, start of frame, resume detected, unrecoverable error, root hub change and ownership change request. The core also sends the most significant bit of its frame counter, together with a strobe that marks the moment the frame number copy in shared memory has been updated.

Each event is latched into a 32-bit status register. Only hardware sets status bits, and only software clears them, by writing ones. A set port and a clear port for the enable mask sit next to the status register. The mask also holds a master enable. The status, the enables and the master enable together drive a normal interrupt output and a separate system management interrupt (SMI) output that is reserved for ownership change. A parameter removes the SMI path completely.

Top module: `usb_host_irq_status`

## Requirements
- R1: Status bits sit at these positions: schedule overrun bit 0, done-queue writeback bit 1, start of frame bit 2, resume detected bit 3, unrecoverable error bit 4, frame number overflow bit 5, root hub change bit 6, ownership change bit 30. Every other status bit always reads 0.
- R2: An event strobe that is high at a clock edge sets its status bit at that edge. Reading address 0 returns the status register.
- R3: A write to address 0 clears every status bit whose write data bit is 1. Write data bits of 0 leave the status unchanged. Software can never set a status bit, and hardware never clears one.
- R4: When an event strobe and a software clear hit the same bit at the same edge, the bit stays set.
- R5: The frame number overflow bit sets at an edge where the copy-done strobe is high and the frame counter MSB differs from the MSB captured at the previous copy-done (reset value 0). This works for both directions. MSB changes without a copy-done strobe have no effect.
- R6: Software writes cannot clear the unrecoverable error bit. Only reset clears it.
- R7: A write to address 1 sets the enable bits at the 1 positions of the write data. A write to address 2 clears the enable bits at those positions. The writable enable bits are bits 0 to 6, bit 30 and the master enable at bit 31. Reads of address 1 and address 2 both return the enable mask. Address 3 reads 0 and ignores writes.
- R8: irq_out is a register output. After each edge it equals the OR over bits 0 to 6 of (status AND enable), ANDed with the master enable, all taken from the register contents after that edge. Bit 30 never drives irq_out.
- R9: smi_out is a register output. After each edge it equals status bit 30 AND enable bit 30 AND the master enable, all taken after that edge.
- R10: With HAS_SMI set to 0, status bit 30 and enable bit 30 read 0, and smi_out stays 0.
- R11: After reset, the status, the enables, the captured MSB, irq_out and smi_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_sched_overrun | input | 1 | Schedule overrun event strobe |
| ev_done_head | input | 1 | Done-queue writeback event strobe |
| ev_sof | input | 1 | Start of frame event strobe |
| ev_resume | input | 1 | Resume detected event strobe |
| ev_unrec_err | input | 1 | Unrecoverable system error strobe |
| ev_hub_change | input | 1 | Root hub or port status change strobe |
| ev_own_req | input | 1 | Ownership change request strobe |
| frame_msb | input | 1 | Bit 15 of the frame counter |
| frame_copy_done | input | 1 | Frame number copy in memory updated |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 status, 1 enable set, 2 enable clear |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out | output | 1 | Normal interrupt output |
| smi_out | output | 1 | System management interrupt output |

## Verification
The events are first driven one at a time, so that a wrong bit position shows up on its own. A clear is then issued in the same cycle as the event it targets, which separates event-wins priority from clear-wins priority. The frame counter MSB is toggled both with and without the copy-done strobe, and in both directions, which tells a copy-gated edge detector apart from a plain level or one-direction detector. A long stretch of random strobes, writes and addresses is then compared cycle by cycle with a behavioural model, on a build with SMI and on a build without it. This exposes errors in masking, in master-enable gating and in the timing of the two outputs.

// File: rtl/usb_host_irq_status.sv
module usb_host_irq_status #(
  parameter bit HAS_SMI = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_sched_overrun,
  input  logic        ev_done_head,
  input  logic        ev_sof,
  input  logic        ev_resume,
  input  logic        ev_unrec_err,
  input  logic        ev_hub_change,
  input  logic        ev_own_req,
  input  logic        frame_msb,
  input  logic        frame_copy_done,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_out,
  output logic        smi_out
);

  localparam logic [1:0]  A_STAT   = 2'd0;
  localparam logic [1:0]  A_EN_SET = 2'd1;
  localparam logic [1:0]  A_EN_CLR = 2'd2;
  localparam int          UE_BIT   = 4;
  localparam int          OC_BIT   = 30;
  localparam int          MIE_BIT  = 31;
  localparam logic [31:0] NORM_MASK = 32'h0000_007F;
  localparam logic [31:0] OC_MASK   = HAS_SMI ? (32'h1 << OC_BIT) : 32'h0;
  localparam logic [31:0] STAT_MASK = NORM_MASK | OC_MASK;
  localparam logic [31:0] EN_MASK   = STAT_MASK | (32'h1 << MIE_BIT);
  localparam logic [31:0] UE_KEEP   = ~(32'h1 << UE_BIT);

  logic [31:0] stat_q, en_q, stat_d, en_d, set_vec, clr_vec;
  logic        msb_seen_q, fno_hit, irq_d, smi_d;

  assign fno_hit = frame_copy_done && (frame_msb != msb_seen_q);

  assign set_vec = {1'b0, ev_own_req, 23'b0, ev_hub_change, fno_hit, ev_unrec_err,
                    ev_resume, ev_sof, ev_done_head, ev_sched_overrun} & STAT_MASK;

  assign clr_vec = (reg_wr && reg_addr == A_STAT) ? (reg_wdata & UE_KEEP) : 32'h0;

  assign stat_d = ((stat_q & ~clr_vec) | set_vec) & STAT_MASK;

  always_comb begin
    en_d = en_q;
    if (reg_wr && reg_addr == A_EN_SET) en_d = en_q | (reg_wdata & EN_MASK);
    else if (reg_wr && reg_addr == A_EN_CLR) en_d = en_q & ~reg_wdata;
  end

  assign irq_d = (|(stat_d & en_d & NORM_MASK)) && en_d[MIE_BIT];
  assign smi_d = HAS_SMI && stat_d[OC_BIT] && en_d[OC_BIT] && en_d[MIE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q     <= '0;
      en_q       <= '0;
      msb_seen_q <= 1'b0;
      irq_out    <= 1'b0;
      smi_out    <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      en_q    <= en_d;
      irq_out <= irq_d;
      smi_out <= smi_d;
      if (frame_copy_done) msb_seen_q <= frame_msb;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:             reg_rdata = stat_q;
      A_EN_SET, A_EN_CLR: reg_rdata = en_q;
      default:            reg_rdata = 32'h0;
    endcase
  end

  assert_hw_never_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_sw_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_sched_overrun && !ev_done_head && !ev_sof && !ev_resume && !ev_unrec_err &&
     !ev_hub_change && !ev_own_req && !frame_copy_done)
    |=> ((stat_q & ~$past(stat_q)) == 32'h0));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> stat_q[2]);

  assert_fno_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_copy_done && frame_msb != msb_seen_q) |=> stat_q[5]);

  assert_ue_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[UE_BIT] |=> stat_q[UE_BIT]);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (en_q[MIE_BIT] && (|(stat_q & en_q & NORM_MASK))));

  assert_smi_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_out |-> (stat_q[OC_BIT] && en_q[OC_BIT] && en_q[MIE_BIT]));

  generate
    if (!HAS_SMI) begin : g_no_smi
      assert_no_smi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_out && !stat_q[OC_BIT] && !en_q[OC_BIT]);
    end
  endgenerate

endmodule

// File: tb/tb_usb_host_irq_status.sv
module tb_usb_host_irq_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_so = 0, ev_wdh = 0, ev_sf = 0, ev_rd = 0, ev_ue = 0, ev_rh = 0, ev_oc = 0;
  logic fmsb = 0, fcopy = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata_a, rdata_b;
  logic irq_a, smi_a, irq_b, smi_b;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur = "R11";
  logic [31:0] mstat = 0, men = 0;
  logic mmsb = 0;

  always #4 clk = ~clk;

  usb_host_irq_status #(.HAS_SMI(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ev_sched_overrun(ev_so), .ev_done_head(ev_wdh), .ev_sof(ev_sf),
    .ev_resume(ev_rd), .ev_unrec_err(ev_ue), .ev_hub_change(ev_rh), .ev_own_req(ev_oc),
    .frame_msb(fmsb), .frame_copy_done(fcopy), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata_a), .irq_out(irq_a), .smi_out(smi_a));

  usb_host_irq_status #(.HAS_SMI(1'b0)) dut_nosmi (
    .clk(clk), .rst_n(rst_n), .ev_sched_overrun(ev_so), .ev_done_head(ev_wdh), .ev_sof(ev_sf),
    .ev_resume(ev_rd), .ev_unrec_err(ev_ue), .ev_hub_change(ev_rh), .ev_own_req(ev_oc),
    .frame_msb(fmsb), .frame_copy_done(fcopy), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata_b), .irq_out(irq_b), .smi_out(smi_b));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [31:0] s, logic [31:0] e, logic [1:0] a);
    if (a == 2'd0) return s;
    if (a == 2'd3) return 32'h0;
    return e;
  endfunction

  task automatic compare_all();
    logic [31:0] nb = ~(32'h1 << 30);
    chk(cur, rdata_a, exp_rd(mstat, men, addr));
    chk("R8", {31'b0, irq_a}, {31'b0, ((mstat & men & 32'h7F) != 0) && men[31]});
    chk("R9", {31'b0, smi_a}, {31'b0, mstat[30] & men[30] & men[31]});
    chk("R10", rdata_b, exp_rd(mstat & nb, men & nb, addr));
    chk("R10", {31'b0, irq_b}, {31'b0, ((mstat & men & 32'h7F) != 0) && men[31]});
    chk("R10", {31'b0, smi_b}, 32'h0);
  endtask

  task automatic model_edge();
    logic [31:0] setv, clrv;
    setv = {1'b0, ev_oc, 23'b0, ev_rh, 1'b0, ev_ue, ev_rd, ev_sf, ev_wdh, ev_so};
    if (fcopy) begin
      if (fmsb != mmsb) setv[5] = 1'b1;
      mmsb = fmsb;
    end
    clrv = (wr && addr == 2'd0) ? (wdata & ~32'h10) : 32'h0;
    mstat = ((mstat & ~clrv) | setv) & 32'h4000_007F;
    if (wr && addr == 2'd1) men = men | (wdata & 32'hC000_007F);
    else if (wr && addr == 2'd2) men = men & ~wdata;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    {ev_so, ev_wdh, ev_sf, ev_rd, ev_ue, ev_rh, ev_oc, fcopy, wr} = '0;
    compare_all();
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc();
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1 chk(tag, rdata_a, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) rd(a[1:0], 32'h0, "R11");
    chk("R11", {30'b0, irq_a, smi_a}, 32'h0);
    addr = 0;
    rst_n = 1'b1;
    cyc();

    cur = "R2";
    ev_so = 1; cyc(); rd(0, 32'h1, "R2");
    ev_wdh = 1; cyc(); rd(0, 32'h3, "R2");
    ev_sf = 1; cyc(); ev_rd = 1; cyc(); ev_rh = 1; cyc();
    rd(0, 32'h4F, "R2");
    ev_oc = 1; cyc(); rd(0, 32'h4000_004F, "R1");

    cur = "R3";
    wreg(0, 32'h0); rd(0, 32'h4000_004F, "R3");
    wreg(0, 32'h0000_0005); rd(0, 32'h4000_004A, "R3");
    repeat (5) cyc(); rd(0, 32'h4000_004A, "R3");
    wreg(0, 32'hFFFF_FFFF); rd(0, 32'h0, "R3");

    cur = "R4";
    ev_sf = 1; addr = 0; wdata = 32'h4; wr = 1; cyc(); rd(0, 32'h4, "R4");
    wreg(0, 32'h4);

    cur = "R5";
    fmsb = 1; cyc(); cyc(); rd(0, 32'h0, "R5");
    fcopy = 1; cyc(); rd(0, 32'h20, "R5");
    wreg(0, 32'h20);
    fcopy = 1; cyc(); rd(0, 32'h0, "R5");
    fmsb = 0; fcopy = 1; cyc(); rd(0, 32'h20, "R5");
    wreg(0, 32'h20);

    cur = "R6";
    ev_ue = 1; cyc(); wreg(0, 32'hFFFF_FFFF); rd(0, 32'h10, "R6");

    cur = "R7";
    wreg(1, 32'hFFFF_FFFF); rd(1, 32'hC000_007F, "R7"); rd(2, 32'hC000_007F, "R7");
    wreg(2, 32'h8000_0010); rd(1, 32'h4000_006F, "R7");
    wreg(3, 32'hFFFF_FFFF); rd(3, 32'h0, "R7"); rd(2, 32'h4000_006F, "R7");

    cur = "R8";
    ev_sf = 1; cyc(); chk("R8", {31'b0, irq_a}, 32'h0);
    wreg(1, 32'h8000_0000); chk("R8", {31'b0, irq_a}, 32'h1);
    wreg(0, 32'h4); chk("R8", {31'b0, irq_a}, 32'h0);

    cur = "R9";
    ev_oc = 1; cyc(); chk("R9", {31'b0, smi_a}, 32'h1); chk("R9", {31'b0, irq_a}, 32'h0);
    wreg(0, 32'h4000_0000); chk("R9", {31'b0, smi_a}, 32'h0);

    cur = "R10";
    ev_oc = 1; cyc(); addr = 0; #1 chk("R10", rdata_b & 32'h4000_0000, 32'h0);

    cur = "R3";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r = $urandom;
      {ev_so, ev_wdh, ev_sf, ev_rd, ev_rh, ev_oc} = (r[3:0] == 0) ? r[9:4] : 6'b0;
      ev_ue = (r[15:10] == 0);
      fmsb = r[16] ^ r[17] ? ~fmsb : fmsb;
      fcopy = r[18];
      addr = r[20:19];
      wr = r[22:21] == 0;
      wdata = $urandom;
      cyc();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule